// File: doc/BRIEF.md
# Termination-Fault Counter Peak Capture

This block watches two 5-bit termination-fault counters. Each counter has its own peak register. A 3-bit command, written over the register bus, does three things. It picks whether each read-back value shows the live counter or the tracked peak. It picks whether the peaks follow the largest or the smallest value seen. It reloads the peaks with the start value for that direction. The counter values are registered on every clock, and the peak registers follow the registered copies.

The block also raises a fault status bit for each channel. It compares each registered counter with a threshold held in the block. There is one threshold for fast-edge operation and one for slow-edge operation, and the resolved edge-rate select chooses between them. Software reloads both thresholds through a single write strobe. The command decode uses these codes: 000 clears the peaks for maximum tracking, 001 freezes channel A onto its peak, 010 freezes channel B onto its peak, and 101 presets the peaks for minimum tracking.

Top module: `tf_peak_capture`

## Requirements
- R1: After reset, both read-back outputs are 0 and both fault bits are 0. The fast-edge threshold starts at 9 (4'b1001) and the slow-edge threshold starts at 5 (4'b0101).
- R2: When a channel is in live view, its read-back output equals the counter value sampled at the previous rising clock edge.
- R3: A command write of 3'b000 sets both peak registers to 0, selects maximum tracking and returns both channels to live view, all from the next edge.
- R4: A command write of 3'b001 switches channel A's read-back to its peak register from the next edge. Channel B's view is not changed.
- R5: A command write of 3'b010 switches channel B's read-back to its peak register from the next edge. Channel A's view is not changed.
- R6: In maximum tracking, a peak register loads the sampled counter whenever that value is greater than the stored peak, and otherwise keeps its value.
- R7: A command write of 3'b101 sets both peak registers to 31, selects minimum tracking and returns both channels to live view, all from the next edge.
- R8: In minimum tracking, a peak register loads the sampled counter whenever that value is smaller than the stored peak, and otherwise keeps its value.
- R9: Command writes of 3'b011, 3'b100, 3'b110 and 3'b111 leave the tracking direction and both channel views unchanged. Peak tracking continues as before.
- R10: A channel's fault bit is 1 exactly when its sampled counter is strictly greater than the active threshold. A counter equal to the threshold gives 0.
- R11: When the slow-edge select input is 1, the slow-edge threshold is active. When it is 0, the fast-edge threshold is active.
- R12: A threshold write loads both threshold registers from the threshold data inputs at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_a_i | input | 5 | Channel A fault counter value |
| cnt_b_i | input | 5 | Channel B fault counter value |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_i | input | 3 | Command code |
| thr_we_i | input | 1 | Threshold write strobe |
| thr_fast_i | input | 4 | New fast-edge threshold |
| thr_slow_i | input | 4 | New slow-edge threshold |
| slow_edge_i | input | 1 | Resolved edge-rate select (1 = slow edges) |
| rd_a_o | output | 5 | Channel A read-back (live or peak) |
| rd_b_o | output | 5 | Channel B read-back (live or peak) |
| fault_a_o | output | 1 | Channel A termination fault |
| fault_b_o | output | 1 | Channel B termination fault |

## Verification
The assertions check several rules on every cycle. The three command kinds must set the tracking direction and the view state they promise, and reserved codes must leave that state alone. A peak may only move in the active direction and must land on its start value after a clear. A threshold write must carry its data through. What only the bench scenarios can show is the set of actual values that appear at the read-back ports. That includes the one-cycle lag of live view, the exact peak reached after a given counter sequence, and the fault bit at the boundary where the counter equals the threshold for each edge-rate setting.

// File: rtl/tfp_pkg.sv
package tfp_pkg;
  localparam int CNT_W = 5;
  localparam int THR_W = 4;
  localparam int NCH   = 2;

  localparam logic [2:0] CMD_CLR_MAX = 3'b000;
  localparam logic [2:0] CMD_SET_MIN = 3'b101;

  typedef enum logic {TRK_MAX = 1'b0, TRK_MIN = 1'b1} trk_mode_e;
endpackage

// File: rtl/tfp_cmd_ctrl.sv
module tfp_cmd_ctrl
  import tfp_pkg::*;
#(
  parameter int NCH_P = NCH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we_i,
  input  logic [2:0]       cmd_i,
  output trk_mode_e        mode_o,
  output logic [NCH_P-1:0] view_o,
  output logic             clr_o,
  output logic             clr_min_o
);
  trk_mode_e        mode_q, mode_d;
  logic [NCH_P-1:0] view_q, view_d;
  logic             is_clr_max, is_set_min;

  assign is_clr_max = cmd_we_i && (cmd_i == CMD_CLR_MAX);
  assign is_set_min = cmd_we_i && (cmd_i == CMD_SET_MIN);

  always_comb begin
    mode_d = mode_q;
    view_d = view_q;
    if (is_clr_max) begin
      mode_d = TRK_MAX;
      view_d = '0;
    end else if (is_set_min) begin
      mode_d = TRK_MIN;
      view_d = '0;
    end else if (cmd_we_i) begin
      for (int i = 0; i < NCH_P; i++) begin
        if (cmd_i == 3'(i + 1)) view_d[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= TRK_MAX;
      view_q <= '0;
    end else begin
      mode_q <= mode_d;
      view_q <= view_d;
    end
  end

  assign mode_o    = mode_q;
  assign view_o    = view_q;
  assign clr_o     = is_clr_max || is_set_min;
  assign clr_min_o = is_set_min;

  assert_clr_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we_i && cmd_i == 3'b000) |=> (mode_q == TRK_MAX && view_q == '0));
  assert_set_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we_i && cmd_i == 3'b101) |=> (mode_q == TRK_MIN && view_q == '0));
  assert_hold_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we_i && cmd_i == 3'b001) |=> view_q[0]);
  assert_rsvd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we_i && (cmd_i inside {3'b011, 3'b100, 3'b110, 3'b111}))
      |=> ($stable(mode_q) && $stable(view_q)));
endmodule

// File: rtl/tfp_peak_track.sv
module tfp_peak_track
  import tfp_pkg::*;
#(
  parameter int CNT_W_P = CNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W_P-1:0] cnt_i,
  input  trk_mode_e          mode_i,
  input  logic               clr_i,
  input  logic               clr_min_i,
  input  logic               view_i,
  output logic [CNT_W_P-1:0] live_o,
  output logic [CNT_W_P-1:0] rd_o
);
  logic [CNT_W_P-1:0] cnt_q;
  logic [CNT_W_P-1:0] peak_q, peak_d;
  logic               load_en;

  always_comb begin
    load_en = (mode_i == TRK_MIN) ? (cnt_q < peak_q) : (cnt_q > peak_q);
    peak_d  = peak_q;
    if (clr_i)        peak_d = clr_min_i ? '1 : '0;
    else if (load_en) peak_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      peak_q <= '0;
    end else begin
      cnt_q  <= cnt_i;
      peak_q <= peak_d;
    end
  end

  assign live_o = cnt_q;
  assign rd_o   = view_i ? peak_q : cnt_q;

  assert_max_mono_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && mode_i == TRK_MAX) |=> (peak_q >= $past(peak_q) && peak_q >= $past(cnt_q)));
  assert_min_mono_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && mode_i == TRK_MIN) |=> (peak_q <= $past(peak_q) && peak_q <= $past(cnt_q)));
  assert_clr_val_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !clr_min_i) |=> (peak_q == '0));
  assert_min_val_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && clr_min_i) |=> (peak_q == '1));
endmodule

// File: rtl/tfp_thresh.sv
module tfp_thresh
  import tfp_pkg::*;
#(
  parameter int               CNT_W_P  = CNT_W,
  parameter int               THR_W_P  = THR_W,
  parameter int               NCH_P    = NCH,
  parameter logic [THR_W_P-1:0] FAST_RST = 4'b1001,
  parameter logic [THR_W_P-1:0] SLOW_RST = 4'b0101
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            thr_we_i,
  input  logic [THR_W_P-1:0]              fast_d_i,
  input  logic [THR_W_P-1:0]              slow_d_i,
  input  logic                            slow_sel_i,
  input  logic [NCH_P-1:0][CNT_W_P-1:0]   live_i,
  output logic [NCH_P-1:0]                fault_o
);
  logic [THR_W_P-1:0] fast_q, fast_d, slow_q, slow_d;
  logic [CNT_W_P-1:0] thr_act;

  always_comb begin
    fast_d = fast_q;
    slow_d = slow_q;
    if (thr_we_i) begin
      fast_d = fast_d_i;
      slow_d = slow_d_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_q <= FAST_RST;
      slow_q <= SLOW_RST;
    end else begin
      fast_q <= fast_d;
      slow_q <= slow_d;
    end
  end

  assign thr_act = CNT_W_P'(slow_sel_i ? slow_q : fast_q);

  for (genvar c = 0; c < NCH_P; c++) begin : g_cmp
    assign fault_o[c] = live_i[c] > thr_act;
  end

  assert_thr_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
    thr_we_i |=> (fast_q == $past(fast_d_i) && slow_q == $past(slow_d_i)));
  assert_thr_keep_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !thr_we_i |=> ($stable(fast_q) && $stable(slow_q)));
endmodule

// File: rtl/tf_peak_capture.sv
module tf_peak_capture
  import tfp_pkg::*;
#(
  parameter int CNT_W_P = CNT_W,
  parameter int THR_W_P = THR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W_P-1:0] cnt_a_i,
  input  logic [CNT_W_P-1:0] cnt_b_i,
  input  logic               cmd_we_i,
  input  logic [2:0]         cmd_i,
  input  logic               thr_we_i,
  input  logic [THR_W_P-1:0] thr_fast_i,
  input  logic [THR_W_P-1:0] thr_slow_i,
  input  logic               slow_edge_i,
  output logic [CNT_W_P-1:0] rd_a_o,
  output logic [CNT_W_P-1:0] rd_b_o,
  output logic               fault_a_o,
  output logic               fault_b_o
);
  localparam int NC = NCH;

  trk_mode_e                  mode;
  logic [NC-1:0]              view;
  logic                       clr, clr_min;
  logic [NC-1:0][CNT_W_P-1:0] cnt_in, live, rd;
  logic [NC-1:0]              fault;

  assign cnt_in[0] = cnt_a_i;
  assign cnt_in[1] = cnt_b_i;

  tfp_cmd_ctrl #(.NCH_P(NC)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_we_i  (cmd_we_i),
    .cmd_i     (cmd_i),
    .mode_o    (mode),
    .view_o    (view),
    .clr_o     (clr),
    .clr_min_o (clr_min)
  );

  for (genvar c = 0; c < NC; c++) begin : g_ch
    tfp_peak_track #(.CNT_W_P(CNT_W_P)) u_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_i     (cnt_in[c]),
      .mode_i    (mode),
      .clr_i     (clr),
      .clr_min_i (clr_min),
      .view_i    (view[c]),
      .live_o    (live[c]),
      .rd_o      (rd[c])
    );
  end

  tfp_thresh #(.CNT_W_P(CNT_W_P), .THR_W_P(THR_W_P), .NCH_P(NC)) u_thr (
    .clk        (clk),
    .rst_n      (rst_n),
    .thr_we_i   (thr_we_i),
    .fast_d_i   (thr_fast_i),
    .slow_d_i   (thr_slow_i),
    .slow_sel_i (slow_edge_i),
    .live_i     (live),
    .fault_o    (fault)
  );

  assign rd_a_o    = rd[0];
  assign rd_b_o    = rd[1];
  assign fault_a_o = fault[0];
  assign fault_b_o = fault[1];
endmodule

// File: tb/tf_peak_capture_tb.sv
module tf_peak_capture_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] cnt_a, cnt_b;
  logic       cmd_we;
  logic [2:0] cmd;
  logic       thr_we;
  logic [3:0] thr_fast, thr_slow;
  logic       slow_edge;
  logic [4:0] rd_a, rd_b;
  logic       fault_a, fault_b;

  int checks = 0;
  int failures = 0;

  int m_min;
  int m_view[2];
  int m_peak[2];
  int m_cnt[2];
  int m_fast, m_slow;

  int nx_we = 0;
  int nx_fast = 0;
  int nx_slow = 0;

  always #5 clk = ~clk;

  tf_peak_capture u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_a_i(cnt_a), .cnt_b_i(cnt_b),
    .cmd_we_i(cmd_we), .cmd_i(cmd), .thr_we_i(thr_we),
    .thr_fast_i(thr_fast), .thr_slow_i(thr_slow), .slow_edge_i(slow_edge),
    .rd_a_o(rd_a), .rd_b_o(rd_b), .fault_a_o(fault_a), .fault_b_o(fault_b)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_rd(int ch);
    return (m_view[ch] != 0) ? m_peak[ch] : m_cnt[ch];
  endfunction

  function automatic int exp_fault(int ch);
    int thr;
    thr = slow_edge ? m_slow : m_fast;
    return (m_cnt[ch] > thr) ? 1 : 0;
  endfunction

  function automatic int track(int pk, int cv);
    if (m_min != 0) return (cv < pk) ? cv : pk;
    return (cv > pk) ? cv : pk;
  endfunction

  task automatic step(string rtag, string ftag, int ca, int cb, int we, int c, int se);
    int n_peak[2];
    int n_view[2];
    int n_min;
    @(negedge clk);
    cnt_a = 5'(ca); cnt_b = 5'(cb); cmd_we = 1'(we); cmd = 3'(c);
    slow_edge = 1'(se);
    thr_we = 1'(nx_we); thr_fast = 4'(nx_fast); thr_slow = 4'(nx_slow);
    n_min = m_min;
    for (int i = 0; i < 2; i++) begin
      n_view[i] = m_view[i];
      n_peak[i] = track(m_peak[i], m_cnt[i]);
    end
    if (we != 0 && (c == 0 || c == 5)) begin
      n_min = (c == 5) ? 1 : 0;
      for (int i = 0; i < 2; i++) begin
        n_view[i] = 0;
        n_peak[i] = (c == 5) ? 31 : 0;
      end
    end else if (we != 0 && c == 1) begin
      n_view[0] = 1;
    end else if (we != 0 && c == 2) begin
      n_view[1] = 1;
    end
    @(posedge clk);
    #1;
    m_min = n_min;
    for (int i = 0; i < 2; i++) begin
      m_view[i] = n_view[i];
      m_peak[i] = n_peak[i];
    end
    m_cnt[0] = ca; m_cnt[1] = cb;
    if (nx_we != 0) begin
      m_fast = nx_fast; m_slow = nx_slow;
    end
    chk(rtag, int'(rd_a), exp_rd(0));
    chk(rtag, int'(rd_b), exp_rd(1));
    chk(ftag, int'(fault_a), exp_fault(0));
    chk(ftag, int'(fault_b), exp_fault(1));
    nx_we = 0;
  endtask

  initial begin
    #1500000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cnt_a = '0; cnt_b = '0; cmd_we = 1'b0; cmd = '0;
    thr_we = 1'b0; thr_fast = '0; thr_slow = '0; slow_edge = 1'b0;
    m_min = 0; m_view = '{0, 0}; m_peak = '{0, 0}; m_cnt = '{0, 0};
    m_fast = 9; m_slow = 5;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 rd_a reset", int'(rd_a), 0);
    chk("R1 rd_b reset", int'(rd_b), 0);
    chk("R1 fault_a reset", int'(fault_a), 0);
    chk("R1 fault_b reset", int'(fault_b), 0);

    // default fast threshold 9: 9 not over, 10 over
    step("R2", "R1", 9, 10, 0, 0, 0);
    chk("R1 fast default equal", int'(fault_a), 0);
    chk("R1 fast default above", int'(fault_b), 1);
    // default slow threshold 5
    step("R2", "R11", 5, 6, 0, 0, 1);
    chk("R11 slow default equal", int'(fault_a), 0);
    chk("R11 slow default above", int'(fault_b), 1);
    step("R2", "R10", 17, 2, 0, 0, 0);
    chk("R2 live lag", int'(rd_a), 17);

    // maximum tracking
    step("R3", "R10", 3, 1, 1, 0, 0);
    step("R6", "R10", 12, 4, 0, 0, 0);
    step("R6", "R10", 7, 30, 0, 0, 0);
    step("R6", "R10", 7, 8, 0, 0, 0);
    step("R4", "R10", 7, 8, 1, 1, 0);
    chk("R6 max peak A", int'(rd_a), 12);
    chk("R4 B stays live", int'(rd_b), 8);
    step("R5", "R10", 0, 0, 1, 2, 0);
    chk("R5 peak B", int'(rd_b), 30);
    chk("R5 A still peak", int'(rd_a), 12);

    // reserved codes
    for (int k = 0; k < 4; k++) begin
      int rc;
      rc = (k == 0) ? 3 : (k == 1) ? 4 : (k == 2) ? 6 : 7;
      step("R9", "R10", 0, 0, 1, rc, 0);
      chk("R9 rsvd A", int'(rd_a), 12);
      chk("R9 rsvd B", int'(rd_b), 30);
    end

    // minimum tracking
    step("R7", "R10", 20, 25, 1, 5, 0);
    chk("R7 live after preset", int'(rd_a), 20);
    step("R8", "R10", 4, 25, 0, 0, 0);
    step("R8", "R10", 9, 25, 0, 0, 0);
    step("R8", "R10", 9, 25, 0, 0, 0);
    step("R8", "R10", 9, 25, 1, 1, 0);
    chk("R8 min peak A", int'(rd_a), 4);
    step("R8", "R10", 9, 25, 1, 2, 0);
    chk("R8 min peak B", int'(rd_b), 25);
    step("R7", "R10", 31, 31, 1, 5, 0);
    step("R7", "R10", 31, 31, 0, 0, 0);
    step("R7", "R10", 31, 31, 1, 1, 0);
    chk("R7 preset 31 held", int'(rd_a), 31);
    step("R9", "R10", 31, 31, 1, 6, 0);
    chk("R9 rsvd keeps view", int'(rd_a), 31);
    step("R9", "R10", 2, 31, 0, 0, 0);
    step("R9", "R10", 2, 31, 0, 0, 0);
    chk("R9 min mode kept", int'(rd_a), 2);

    // threshold reload
    nx_we = 1; nx_fast = 2; nx_slow = 12;
    step("R3", "R12", 3, 2, 1, 0, 0);
    chk("R12 fast over", int'(fault_a), 1);
    chk("R10 fast equal", int'(fault_b), 0);
    step("R2", "R12", 12, 13, 0, 0, 1);
    chk("R10 slow equal", int'(fault_a), 0);
    chk("R12 slow over", int'(fault_b), 1);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      int we, c;
      we = (($urandom % 4) == 0) ? 1 : 0;
      c  = $urandom % 8;
      if (($urandom % 50) == 0) begin
        nx_we = 1; nx_fast = $urandom % 16; nx_slow = $urandom % 16;
      end
      step("R2 R6 R8 random", "R10 R11 random", $urandom % 32, $urandom % 32,
           we, c, $urandom % 2);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule